// File: doc/BRIEF.md
# Receive Error Flag Generator

This block produces one receive-error flag for a biphase-mark digital audio receiver. It does not recover the clock or decode the line. It takes the status outputs of those stages: a loss-of-lock level, a per-subframe parity result, a sample-rate-change pulse and a non-PCM level with its enable bit. It also takes the recovered left/right word clock, and both edges of that clock count as word-clock edges.

The flag rises on any of four conditions: loss of lock, a run of parity errors that reaches the run limit, non-PCM data while non-PCM reporting is enabled, or a sample-rate change. A rate change raises the flag on the very next system clock. Every other rise and every fall waits for a word-clock edge. After each rise the flag stays high for at least a minimum hold time. That time is counted by a millisecond prescaler driven from the system clock, and the hold parameter is clamped to the range 45 to 300 ms. Once the hold has run out and no error source is active, the flag drops at the next word-clock edge.

Top module: `rx_err_flag`

## Requirements
- R1: After reset, err_flag is 0 and the parity-run count is 0.
- R2: While lock_lost is 1, the flag rises on the clock that follows a word-clock edge (a change of lrck).
- R3: The flag rises at a word-clock edge once par_stb has carried par_bad=1 on RUN_LIMIT (default 9) subframes in a row. A run of RUN_LIMIT-1 bad subframes leaves it low.
- R4: A subframe strobe with par_bad=0 clears the parity-run count to 0.
- R5: Once raised, the flag stays high for at least HOLD_MS*CLK_KHZ system clocks, even when every error source is already clear.
- R6: The flag falls at the first word-clock edge at which the hold has expired and no error source is active.
- R7: Apart from a rise caused by rate_chg_stb, err_flag changes only on the clock that follows a word-clock edge.
- R8: rate_chg_stb=1 makes err_flag 1 on the next clock with no word-clock edge needed, and it restarts the hold time even when the flag is already high.
- R9: nonpcm_det raises the flag at a word-clock edge only when nonpcm_en=1. With nonpcm_en=0 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lrck | input | 1 | Recovered word clock, synchronous to clk; either edge is a word-clock edge |
| lock_lost | input | 1 | Recovery loop has lost lock |
| par_stb | input | 1 | One-cycle strobe per received subframe |
| par_bad | input | 1 | Parity result for the strobed subframe (1 = odd, error) |
| rate_chg_stb | input | 1 | One-cycle pulse on a detected sample-rate change |
| nonpcm_det | input | 1 | Incoming data is flagged as non-PCM |
| nonpcm_en | input | 1 | Enables reporting of non-PCM data on the flag |
| err_flag | output | 1 | Receive-error flag |

## Verification
The hardest case to reach from the ports is a condition that is present while no word-clock edge arrives. Examples are lock loss without an edge, or a hold that has expired while lrck sits still. In both, the flag must wait, and a free-running lrck never exposes a design that ignores the edge. The bench therefore freezes lrck on demand, raises lock loss and later lets the hold run out during the freeze, and shows that the flag moves only when lrck starts toggling again. The hold restart is reached by a second rate-change pulse sent partway through a running hold, so that the flag outlives the first hold window.

// File: rtl/rxef_pkg.sv
package rxef_pkg;

  localparam int HOLD_MS_MIN = 45;
  localparam int HOLD_MS_MAX = 300;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_RAISE_NOW,
    EV_RAISE_EDGE,
    EV_RELEASE
  } flag_ev_e;

  function automatic int clamp_hold_ms(int ms);
    if (ms < HOLD_MS_MIN) return HOLD_MS_MIN;
    if (ms > HOLD_MS_MAX) return HOLD_MS_MAX;
    return ms;
  endfunction

  function automatic int bits_for(int value);
    return (value < 2) ? 1 : $clog2(value + 1);
  endfunction

endpackage

// File: rtl/rxef_edge_detect.sv
module rxef_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck,
  output logic lr_edge
);
  logic lrck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lrck_q <= 1'b0;
    else        lrck_q <= lrck;
  end

  assign lr_edge = lrck ^ lrck_q;
endmodule

// File: rtl/rxef_run_counter.sv
module rxef_run_counter #(
  parameter int RUN_LIMIT = 9,
  localparam int RUN_W = rxef_pkg::bits_for(RUN_LIMIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             par_stb,
  input  logic             par_bad,
  output logic [RUN_W-1:0] run_cnt,
  output logic             run_err
);
  localparam logic [RUN_W-1:0] LIMIT = RUN_W'(RUN_LIMIT);

  function automatic logic [RUN_W-1:0] run_next(logic [RUN_W-1:0] cur, logic bad);
    if (!bad)         return '0;
    if (cur >= LIMIT) return LIMIT;
    return cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       run_cnt <= '0;
    else if (par_stb) run_cnt <= run_next(run_cnt, par_bad);
  end

  assign run_err = (run_cnt >= LIMIT);
endmodule

// File: rtl/rxef_hold_timer.sv
module rxef_hold_timer #(
  parameter int CLK_KHZ = 12288,
  parameter int HOLD_MS = 100,
  localparam int HOLD_EFF = rxef_pkg::clamp_hold_ms(HOLD_MS),
  localparam int MS_W  = rxef_pkg::bits_for(HOLD_EFF),
  localparam int PRE_W = rxef_pkg::bits_for(CLK_KHZ)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic hold_done
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_KHZ - 1);
  localparam logic [MS_W-1:0]  MS_LOAD  = MS_W'(HOLD_EFF);

  logic [PRE_W-1:0] pre_cnt;
  logic [MS_W-1:0]  ms_left;
  logic             ms_tick;

  assign ms_tick   = (pre_cnt == PRE_LAST);
  assign hold_done = (ms_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      ms_left <= '0;
    end else if (load) begin
      pre_cnt <= '0;
      ms_left <= MS_LOAD;
    end else if (!hold_done) begin
      if (ms_tick) begin
        pre_cnt <= '0;
        ms_left <= ms_left - 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_err_flag.sv
module rx_err_flag #(
  parameter int CLK_KHZ   = 12288,
  parameter int HOLD_MS   = 100,
  parameter int RUN_LIMIT = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck,
  input  logic lock_lost,
  input  logic par_stb,
  input  logic par_bad,
  input  logic rate_chg_stb,
  input  logic nonpcm_det,
  input  logic nonpcm_en,
  output logic err_flag
);
  import rxef_pkg::*;

  localparam int RUN_W = bits_for(RUN_LIMIT);

  logic             lr_edge;
  logic [RUN_W-1:0] run_cnt;
  logic             run_err;
  logic             hold_done;
  logic             hold_load;
  logic             src_act;
  flag_ev_e         flag_ev;

  rxef_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lrck    (lrck),
    .lr_edge (lr_edge)
  );

  rxef_run_counter #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .par_stb (par_stb),
    .par_bad (par_bad),
    .run_cnt (run_cnt),
    .run_err (run_err)
  );

  rxef_hold_timer #(.CLK_KHZ(CLK_KHZ), .HOLD_MS(HOLD_MS)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (hold_load),
    .hold_done (hold_done)
  );

  assign src_act = lock_lost | run_err | (nonpcm_en & nonpcm_det);

  always_comb begin
    if (rate_chg_stb)                               flag_ev = EV_RAISE_NOW;
    else if (!err_flag && lr_edge && src_act)       flag_ev = EV_RAISE_EDGE;
    else if (err_flag && lr_edge && !src_act && hold_done)
                                                    flag_ev = EV_RELEASE;
    else                                            flag_ev = EV_NONE;
  end

  assign hold_load = (flag_ev == EV_RAISE_NOW) || (flag_ev == EV_RAISE_EDGE);

  always_ff @(posedge clk) begin
    if (!rst_n) err_flag <= 1'b0;
    else begin
      case (flag_ev)
        EV_RAISE_NOW, EV_RAISE_EDGE: err_flag <= 1'b1;
        EV_RELEASE:                  err_flag <= 1'b0;
        default:                     err_flag <= err_flag;
      endcase
    end
  end
endmodule

// File: rtl/rxef_checker.sv
module rxef_checker #(
  parameter int RUN_LIMIT = 9,
  localparam int RUN_W = rxef_pkg::bits_for(RUN_LIMIT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_lost,
  input logic             par_stb,
  input logic             par_bad,
  input logic             rate_chg_stb,
  input logic             nonpcm_det,
  input logic             nonpcm_en,
  input logic             lr_edge,
  input logic             run_err,
  input logic [RUN_W-1:0] run_cnt,
  input logic             hold_done,
  input logic             err_flag
);
  logic src_any;
  assign src_any = lock_lost | run_err | (nonpcm_en & nonpcm_det);

  a_r2_lock_raise: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost && lr_edge |=> err_flag);

  a_r3_run_raise: assert property (@(posedge clk) disable iff (!rst_n)
    run_err && lr_edge |=> err_flag);

  a_r4_good_clears: assert property (@(posedge clk) disable iff (!rst_n)
    par_stb && !par_bad |=> run_cnt == '0);

  a_r5_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(hold_done));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && lr_edge && !src_any && hold_done && !rate_chg_stb |=> !err_flag);

  a_r7_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_chg_stb && !lr_edge |=> $stable(err_flag));

  a_r8_rate_now: assert property (@(posedge clk) disable iff (!rst_n)
    rate_chg_stb |=> err_flag && !hold_done);

  a_r9_nonpcm_raise: assert property (@(posedge clk) disable iff (!rst_n)
    nonpcm_en && nonpcm_det && lr_edge |=> err_flag);
endmodule

bind rx_err_flag rxef_checker #(.RUN_LIMIT(RUN_LIMIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lock_lost    (lock_lost),
  .par_stb      (par_stb),
  .par_bad      (par_bad),
  .rate_chg_stb (rate_chg_stb),
  .nonpcm_det   (nonpcm_det),
  .nonpcm_en    (nonpcm_en),
  .lr_edge      (lr_edge),
  .run_err      (run_err),
  .run_cnt      (run_cnt),
  .hold_done    (hold_done),
  .err_flag     (err_flag)
);

// File: tb/rx_err_flag_test.sv
module rx_err_flag_test;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ   = 4;
  localparam int HMS   = 45;
  localparam int RUNL  = 9;
  localparam int HOLDC = HMS * KHZ;
  localparam int LR_HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lrck = 1'b0;
  logic lock_lost = 1'b0, par_stb = 1'b0, par_bad = 1'b0;
  logic rate_chg_stb = 1'b0, nonpcm_det = 1'b0, nonpcm_en = 1'b0;
  logic err_flag;
  logic lr_freeze = 1'b0;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  int  m_run = 0;
  int  m_hold = 0;
  bit  m_flag = 0;
  logic m_lrprev = 1'b0;

  rx_err_flag #(.CLK_KHZ(KHZ), .HOLD_MS(HMS), .RUN_LIMIT(RUNL)) uut (
    .clk(clk), .rst_n(rst_n), .lrck(lrck), .lock_lost(lock_lost),
    .par_stb(par_stb), .par_bad(par_bad), .rate_chg_stb(rate_chg_stb),
    .nonpcm_det(nonpcm_det), .nonpcm_en(nonpcm_en), .err_flag(err_flag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // word clock, freezable
  int lr_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && !lr_freeze) begin
      if (lr_cnt == LR_HALF - 1) begin
        lr_cnt <= 0;
        lrck <= ~lrck;
      end else begin
        lr_cnt <= lr_cnt + 1;
      end
    end
  end

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_hold = 0; m_flag = 0; m_lrprev = 1'b0;
    end else begin
      bit edge_seen, active, expired;
      edge_seen = (lrck != m_lrprev);
      active  = lock_lost || (m_run >= RUNL) || (nonpcm_en && nonpcm_det);
      expired = (m_hold == 0);
      if (m_hold > 0) m_hold = m_hold - 1;
      if (rate_chg_stb) begin
        m_flag = 1; m_hold = HOLDC;
      end else if (!m_flag && edge_seen && active) begin
        m_flag = 1; m_hold = HOLDC;
      end else if (m_flag && edge_seen && !active && expired) begin
        m_flag = 0;
      end
      if (par_stb) m_run = par_bad ? ((m_run >= RUNL) ? RUNL : m_run + 1) : 0;
      m_lrprev = lrck;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vectors++;
      if (err_flag !== m_flag) begin
        fails++;
        $display("FAIL %s: cycle compare err_flag actual=%0b expected=%0b at %0t",
                 cur_req, err_flag, m_flag, $time);
      end
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic subframe(logic bad);
    par_stb = 1'b1; par_bad = bad;
    wait_cyc(1);
    par_stb = 1'b0; par_bad = 1'b0;
    wait_cyc(3);
  endtask

  initial begin
    wait_cyc(4);
    check("R1", err_flag, 1'b0, "flag in reset");
    rst_n = 1'b1;
    wait_cyc(3);
    check("R1", err_flag, 1'b0, "flag after reset");

    // R3: run limit
    cur_req = "R3";
    for (int i = 0; i < RUNL - 1; i++) subframe(1'b1);
    wait_cyc(20);
    check("R3", err_flag, 1'b0, "eight bad subframes");
    subframe(1'b1);
    wait_cyc(12);
    check("R3", err_flag, 1'b1, "ninth bad subframe");
    subframe(1'b0);
    cur_req = "R5";
    wait_cyc(140);
    check("R5", err_flag, 1'b1, "still held after parity clears");
    cur_req = "R6";
    wait_cyc(60);
    check("R6", err_flag, 1'b0, "released after hold");

    // R4: good subframe resets run
    cur_req = "R4";
    for (int i = 0; i < RUNL - 1; i++) subframe(1'b1);
    subframe(1'b0);
    for (int i = 0; i < RUNL - 1; i++) subframe(1'b1);
    wait_cyc(20);
    check("R4", err_flag, 1'b0, "run broken by good subframe");
    subframe(1'b0);

    // R2: lock loss
    cur_req = "R2";
    lock_lost = 1'b1;
    wait_cyc(30);
    check("R2", err_flag, 1'b1, "lock loss raises");
    lock_lost = 1'b0;
    cur_req = "R5";
    wait_cyc(140);
    check("R5", err_flag, 1'b1, "hold after lock returns");
    wait_cyc(60);
    check("R6", err_flag, 1'b0, "release after lock hold");

    // R7: no change without word-clock edge
    cur_req = "R7";
    lr_freeze = 1'b1;
    wait_cyc(2);
    lock_lost = 1'b1;
    wait_cyc(30);
    check("R7", err_flag, 1'b0, "lock loss waits for edge");
    lr_freeze = 1'b0;
    wait_cyc(12);
    check("R7", err_flag, 1'b1, "raised at resumed edge");
    lock_lost = 1'b0;
    lr_freeze = 1'b1;
    wait_cyc(HOLDC + 40);
    check("R7", err_flag, 1'b1, "hold expired but frozen clock keeps flag");
    lr_freeze = 1'b0;
    wait_cyc(12);
    check("R6", err_flag, 1'b0, "released at first edge after expiry");

    // R8: rate change, immediate and restart
    cur_req = "R8";
    lr_freeze = 1'b1;
    wait_cyc(2);
    rate_chg_stb = 1'b1;
    wait_cyc(1);
    rate_chg_stb = 1'b0;
    check("R8", err_flag, 1'b1, "rate change raises without edge");
    lr_freeze = 1'b0;
    wait_cyc(100);
    rate_chg_stb = 1'b1;
    wait_cyc(1);
    rate_chg_stb = 1'b0;
    wait_cyc(150);
    check("R8", err_flag, 1'b1, "second rate change restarts hold");
    wait_cyc(60);
    check("R8", err_flag, 1'b0, "released after restarted hold");

    // R9: non-PCM gating
    cur_req = "R9";
    nonpcm_det = 1'b1;
    nonpcm_en = 1'b0;
    wait_cyc(30);
    check("R9", err_flag, 1'b0, "non-PCM ignored when disabled");
    nonpcm_en = 1'b1;
    wait_cyc(12);
    check("R9", err_flag, 1'b1, "non-PCM reported when enabled");
    nonpcm_det = 1'b0;
    wait_cyc(HOLDC + 40);
    check("R9", err_flag, 1'b0, "released after non-PCM clears");

    wait_cyc(5);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL R1: watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule